// File: doc/BRIEF.md
# Encoder Serial Request-Response Controller

This block runs one complete exchange with an absolute rotary encoder over a half-duplex serial line. A one-cycle start pulse sends a request field that carries a 4-bit command code. The block raises a transmit-enable for the external line driver while that field is on the wire. It then listens on the receive input for the encoder's reply.

The reply opens with a control field. That field must carry a fixed sync pattern and a correct parity bit, and its embedded ID sets how many data fields follow. The block stores the status field, the data fields and the CRC field in output registers. It pulses done after a clean exchange. If the exchange fails, it raises exactly one fault flag and drops the transaction.

Every field on the wire has the same shape: a 0 start bit, then 8 data bits sent LSB first, then a 1 delimiter. On transmit, each bit lasts one period of the reference clock, which is synchronised into the system clock domain. On receive, each bit is sampled near its centre, using a count of system clocks per bit. The time the line may sit idle between fields is bounded by a parameter counted in system clocks.

Top module: `encoder_link_ctrl`

## Requirements
- R1: The request field on `tx_o` is a 0 start bit, then data bits 0..7, then a 1 delimiter. The data byte has bits[2:0]=3'b010, bits[6:3]=`cmd_i` and bit 7 = XOR of the four command bits. Each bit lasts one `ref_clk_i` period, and `tx_o` idles at 1.
- R2: `tx_en_o` is high for exactly the ten bit periods of the request field and low at all other times.
- R3: The number of reply data fields comes from the ID received in the reply's control field: ID 2 gives 1 field, ID 3 gives 8 fields, and every other ID gives 3 fields. The reply order is control field, status, D0..D(n-1), CRC.
- R4: The received ID, status, data and CRC are presented on `id_o`, `status_o`, `data_o` and `crc_o`. Dk sits at `data_o[8k+7:8k]`. All of these are cleared when a start is accepted, so data fields not returned read as zero.
- R5: A sync fault (`fault_o`=3'b010) is raised in either of two cases. The first is that received control-field bits[2:0] are not 3'b010, which means the wire does not show 0,0,1,0 counting the start bit. The second is that no start bit arrives within `TIMEOUT_CLKS` system clocks after the request field ends.
- R6: A parity fault (`fault_o`=3'b001) is raised when bit 7 of the received control field differs from the XOR of its bits[6:3].
- R7: An incomplete-message fault (`fault_o`=3'b100) is raised in two cases: the line stays idle for `TIMEOUT_CLKS` clocks while a later field is expected, or any delimiter is sampled as 0. A delimiter fault on the control field takes precedence over the sync and parity checks.
- R8: Any fault ends the transaction at once. Exactly one `fault_o` bit is then set (bit 0 parity, bit 1 sync, bit 2 incomplete), and `done_o` does not pulse.
- R9: `done_o` is high for exactly one cycle after the CRC field of an error-free reply, and `fault_o` is 0 at that moment.
- R10: `fault_o` returns to 0 on the cycle after a start is accepted.
- R11: A start pulse that arrives while a transaction is in progress is ignored. It sends no second request and does not disturb the current transaction.
- R12: After reset, `tx_o`=1, `tx_en_o`=0, `done_o`=0, `fault_o`=0, and all field outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Bit-rate reference clock, synchronised internally |
| start_i | input | 1 | One-cycle request to begin a transaction |
| cmd_i | input | 4 | Command code to send |
| rx_i | input | 1 | Serial reply from the encoder |
| tx_o | output | 1 | Serial request to the encoder |
| tx_en_o | output | 1 | Line driver enable during transmission |
| done_o | output | 1 | One-cycle pulse after an error-free transaction |
| fault_o | output | 3 | Fault flags: bit 0 parity, bit 1 sync, bit 2 incomplete |
| id_o | output | 4 | ID from the received control field |
| status_o | output | 8 | Received status field |
| data_o | output | 64 | Received data fields, Dk at bits 8k+7:8k |
| crc_o | output | 8 | Received CRC field |

## Verification
The bench sweeps all sixteen command codes and replies echoing each one, which covers every reply length. It also runs a reply whose ID differs from the command sent. A design that sized the reply from the command instead would wait for fields that never come and raise an incomplete fault. A design that did not clear the data registers would leak bytes from an 8-field reply into the 3-field reply after it.

The fault cases are a flipped parity bit, a corrupted sync pattern, a silent line, a reply cut short, and a line held low through a delimiter. Held low through the control field, that last case must report incomplete rather than sync. A design that continued after a fault, or raised several flags, would show a done pulse or a wrong flag vector.

A start pulse injected mid-reply must produce no second transmit-enable rise. A design that accepted it would restart the request and lose the reply.

// File: rtl/encrx_pkg.sv
package encrx_pkg;

    localparam int FIELD_BITS = 8;
    localparam int ID_W       = 4;
    localparam int SYNC_W     = 3;
    localparam int MAX_DATA   = 8;
    localparam int FCNT_W     = $clog2(MAX_DATA + 2);
    localparam int IDX_W      = $clog2(MAX_DATA);

    // bit0=0, bit1=1, bit2=0 : with the start bit the wire shows 0,0,1,0
    localparam logic [SYNC_W-1:0] SYNC_CODE = 3'b010;

    typedef struct packed {
        logic incomplete;
        logic sync;
        logic parity;
    } fault_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_CF,
        ST_FIELD
    } ctl_state_t;

    function automatic logic [FIELD_BITS-1:0] build_request(input logic [ID_W-1:0] id);
        build_request = {^id, id, SYNC_CODE};
    endfunction

    function automatic logic [FCNT_W-1:0] reply_fields(input logic [ID_W-1:0] id);
        case (id)
            4'd2:    reply_fields = FCNT_W'(1);
            4'd3:    reply_fields = FCNT_W'(MAX_DATA);
            default: reply_fields = FCNT_W'(3);
        endcase
    endfunction

endpackage

// File: rtl/encrx_ref_tick.sv
module encrx_ref_tick (
    input  logic clk,
    input  logic rst,
    input  logic ref_clk_i,
    output logic tick_o
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], ref_clk_i};
    end

    assign tick_o = sh[1] & ~sh[2];

endmodule

// File: rtl/encrx_tx.sv
module encrx_tx
    import encrx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_i,
    input  logic                  load_i,
    input  logic [FIELD_BITS-1:0] byte_i,
    output logic                  tx_o,
    output logic                  tx_en_o,
    output logic                  fin_o
);
    localparam int FRAME_BITS = FIELD_BITS + 2;
    localparam int CW         = $clog2(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] shr;
    logic [CW-1:0]         left;
    logic                  pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            shr     <= '1;
            left    <= '0;
            pending <= 1'b0;
            tx_en_o <= 1'b0;
            fin_o   <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            if (load_i && !pending && left == '0) begin
                pending <= 1'b1;
                shr     <= {1'b1, byte_i, 1'b0};
            end else if (tick_i) begin
                if (pending) begin
                    pending <= 1'b0;
                    left    <= CW'(FRAME_BITS);
                    tx_en_o <= 1'b1;
                end else if (left != '0) begin
                    shr  <= {1'b1, shr[FRAME_BITS-1:1]};
                    left <= left - CW'(1);
                    if (left == CW'(1)) begin
                        tx_en_o <= 1'b0;
                        fin_o   <= 1'b1;
                    end
                end
            end
        end
    end

    assign tx_o = tx_en_o ? shr[0] : 1'b1;

    // R2: the finish pulse follows directly on the end of the enable window
    p_fin_after_enable_r2: assert property (@(posedge clk) disable iff (rst)
        fin_o |-> (!tx_en_o && $past(tx_en_o)));

endmodule

// File: rtl/encrx_rx_field.sv
module encrx_rx_field
    import encrx_pkg::*;
#(
    parameter int BIT_CLKS     = 80,
    parameter int TIMEOUT_CLKS = 400
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_i,
    input  logic                  arm_i,
    output logic [FIELD_BITS-1:0] byte_o,
    output logic                  got_o,
    output logic                  delim_err_o,
    output logic                  timeout_o
);
    localparam int HALF = (BIT_CLKS / 2 > 0) ? BIT_CLKS / 2 : 1;
    localparam int BW   = $clog2(BIT_CLKS + 1);
    localparam int TW   = $clog2(TIMEOUT_CLKS + 1);
    localparam int XW   = $clog2(FIELD_BITS + 2);

    typedef enum logic [1:0] {R_IDLE, R_WAIT, R_BITS} rx_state_t;

    rx_state_t             st;
    logic [1:0]            sync_q;
    logic                  line;
    logic [BW-1:0]         bcnt;
    logic [XW-1:0]         bidx;
    logic [TW-1:0]         gap;
    logic [FIELD_BITS-1:0] shr;

    assign line   = sync_q[1];
    assign byte_o = shr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= R_IDLE;
            sync_q      <= 2'b11;
            bcnt        <= '0;
            bidx        <= '0;
            gap         <= '0;
            shr         <= '0;
            got_o       <= 1'b0;
            delim_err_o <= 1'b0;
            timeout_o   <= 1'b0;
        end else begin
            sync_q      <= {sync_q[0], rx_i};
            got_o       <= 1'b0;
            delim_err_o <= 1'b0;
            timeout_o   <= 1'b0;
            case (st)
                R_IDLE: begin
                    if (arm_i) begin
                        st  <= R_WAIT;
                        gap <= '0;
                    end
                end
                R_WAIT: begin
                    if (!line) begin
                        st   <= R_BITS;
                        bcnt <= BW'(HALF);
                        bidx <= '0;
                    end else if (gap == TW'(TIMEOUT_CLKS - 1)) begin
                        timeout_o <= 1'b1;
                        st        <= R_IDLE;
                    end else begin
                        gap <= gap + TW'(1);
                    end
                end
                R_BITS: begin
                    if (bcnt != BW'(1)) begin
                        bcnt <= bcnt - BW'(1);
                    end else begin
                        bcnt <= BW'(BIT_CLKS);
                        bidx <= bidx + XW'(1);
                        if (bidx == XW'(FIELD_BITS + 1)) begin
                            st <= R_IDLE;
                            if (line) got_o       <= 1'b1;
                            else      delim_err_o <= 1'b1;
                        end else if (bidx != '0) begin
                            shr <= {line, shr[FIELD_BITS-1:1]};
                        end
                    end
                end
                default: st <= R_IDLE;
            endcase
        end
    end

    // R7: a field ends in exactly one way
    p_single_outcome_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({got_o, delim_err_o, timeout_o}));

    // R7: a timeout can only come out of the idle-line wait
    p_timeout_from_wait_r7: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> $past(st) == R_WAIT);

endmodule

// File: rtl/encoder_link_ctrl.sv
module encoder_link_ctrl
    import encrx_pkg::*;
#(
    parameter int BIT_CLKS     = 80,
    parameter int TIMEOUT_CLKS = 400
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ref_clk_i,
    input  logic                           start_i,
    input  logic [ID_W-1:0]                cmd_i,
    input  logic                           rx_i,
    output logic                           tx_o,
    output logic                           tx_en_o,
    output logic                           done_o,
    output logic [2:0]                     fault_o,
    output logic [ID_W-1:0]                id_o,
    output logic [FIELD_BITS-1:0]          status_o,
    output logic [MAX_DATA*FIELD_BITS-1:0] data_o,
    output logic [FIELD_BITS-1:0]          crc_o
);
    logic                  tick, tx_load, tx_fin;
    logic [FIELD_BITS-1:0] tx_byte;
    logic                  rx_arm, rx_got, rx_delim, rx_to;
    logic [FIELD_BITS-1:0] rxb;

    ctl_state_t                           st;
    fault_t                               flt;
    logic [FCNT_W-1:0]                    fld, nfld;
    logic [MAX_DATA-1:0][FIELD_BITS-1:0]  dat;

    encrx_ref_tick u_tick (
        .clk       (clk),
        .rst       (rst),
        .ref_clk_i (ref_clk_i),
        .tick_o    (tick)
    );

    encrx_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .load_i  (tx_load),
        .byte_i  (tx_byte),
        .tx_o    (tx_o),
        .tx_en_o (tx_en_o),
        .fin_o   (tx_fin)
    );

    encrx_rx_field #(
        .BIT_CLKS     (BIT_CLKS),
        .TIMEOUT_CLKS (TIMEOUT_CLKS)
    ) u_rx (
        .clk         (clk),
        .rst         (rst),
        .rx_i        (rx_i),
        .arm_i       (rx_arm),
        .byte_o      (rxb),
        .got_o       (rx_got),
        .delim_err_o (rx_delim),
        .timeout_o   (rx_to)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            flt      <= '0;
            fld      <= '0;
            nfld     <= '0;
            dat      <= '0;
            id_o     <= '0;
            status_o <= '0;
            crc_o    <= '0;
            tx_byte  <= '1;
            done_o   <= 1'b0;
            rx_arm   <= 1'b0;
            tx_load  <= 1'b0;
        end else begin
            done_o  <= 1'b0;
            rx_arm  <= 1'b0;
            tx_load <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        flt      <= '0;
                        dat      <= '0;
                        id_o     <= '0;
                        status_o <= '0;
                        crc_o    <= '0;
                        tx_byte  <= build_request(cmd_i);
                        tx_load  <= 1'b1;
                        st       <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tx_fin) begin
                        rx_arm <= 1'b1;
                        st     <= ST_CF;
                    end
                end
                ST_CF: begin
                    if (rx_got) begin
                        if (rxb[SYNC_W-1:0] != SYNC_CODE) begin
                            flt.sync <= 1'b1;
                            st       <= ST_IDLE;
                        end else if (^rxb[FIELD_BITS-1:SYNC_W]) begin
                            flt.parity <= 1'b1;
                            st         <= ST_IDLE;
                        end else begin
                            id_o   <= rxb[SYNC_W +: ID_W];
                            nfld   <= reply_fields(rxb[SYNC_W +: ID_W]);
                            fld    <= '0;
                            rx_arm <= 1'b1;
                            st     <= ST_FIELD;
                        end
                    end else if (rx_delim) begin
                        flt.incomplete <= 1'b1;
                        st             <= ST_IDLE;
                    end else if (rx_to) begin
                        flt.sync <= 1'b1;
                        st       <= ST_IDLE;
                    end
                end
                ST_FIELD: begin
                    if (rx_got) begin
                        if (fld == '0) begin
                            status_o <= rxb;
                        end else if (fld <= nfld) begin
                            dat[IDX_W'(fld - FCNT_W'(1))] <= rxb;
                        end else begin
                            crc_o  <= rxb;
                            done_o <= 1'b1;
                            st     <= ST_IDLE;
                        end
                        if (fld <= nfld) begin
                            fld    <= fld + FCNT_W'(1);
                            rx_arm <= 1'b1;
                        end
                    end else if (rx_delim || rx_to) begin
                        flt.incomplete <= 1'b1;
                        st             <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign fault_o = flt;
    assign data_o  = dat;

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_clean_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> fault_o == 3'b000);

    p_fault_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fault_o));

    p_start_bit_first_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en_o) |-> !tx_o);

    p_txen_only_sending_r2: assert property (@(posedge clk) disable iff (rst)
        tx_en_o |-> st == ST_SEND);

    p_clear_on_start_r10: assert property (@(posedge clk) disable iff (rst)
        (start_i && st == ST_IDLE) |=> fault_o == 3'b000);

endmodule

// File: tb/encoder_link_ctrl_test.sv
module encoder_link_ctrl_test;

    localparam int BIT = 8;
    localparam int TO  = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_clk = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  cmd_i = 4'h0;
    logic        rx_i = 1'b1;
    logic        tx_o, tx_en_o, done_o;
    logic [2:0]  fault_o;
    logic [3:0]  id_o;
    logic [7:0]  status_o, crc_o;
    logic [63:0] data_o;

    int n_chk = 0;
    int n_fail = 0;
    int done_cnt = 0;
    int rise_cnt = 0;
    logic txen_prev = 1'b0;

    encoder_link_ctrl #(.BIT_CLKS(BIT), .TIMEOUT_CLKS(TO)) uut (
        .clk(clk), .rst(rst), .ref_clk_i(ref_clk), .start_i(start_i),
        .cmd_i(cmd_i), .rx_i(rx_i), .tx_o(tx_o), .tx_en_o(tx_en_o),
        .done_o(done_o), .fault_o(fault_o), .id_o(id_o),
        .status_o(status_o), .data_o(data_o), .crc_o(crc_o)
    );

    always #2.5 clk = ~clk;

    always begin
        repeat (BIT / 2) @(negedge clk);
        ref_clk = ~ref_clk;
    end

    always @(negedge clk) begin
        if (done_o) done_cnt++;
        if (tx_en_o && !txen_prev) rise_cnt++;
        txen_prev = tx_en_o;
    end

    function automatic logic [7:0] cf_of(input logic [3:0] id);
        return {^id, id, 3'b010};
    endfunction

    function automatic int nfields(input logic [3:0] id);
        if (id == 4'd2) return 1;
        if (id == 4'd3) return 8;
        return 3;
    endfunction

    function automatic logic [7:0] dv(input logic [3:0] id, input int k);
        return 8'(int'(id) * 37 + k * 11 + 5);
    endfunction

    function automatic logic [7:0] sv(input logic [3:0] id);
        return {4'h0, id} ^ 8'hA5;
    endfunction

    function automatic logic [7:0] cv(input logic [3:0] id);
        return 8'(int'(id) * 3 + 1);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic idle(input int cycles);
        rx_i = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic send_field(input logic [7:0] b, input logic stop);
        rx_i = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_i = b[i];
            repeat (BIT) @(negedge clk);
        end
        rx_i = stop;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic do_start(input logic [3:0] c);
        @(negedge clk);
        start_i = 1'b1;
        cmd_i   = c;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic capture_tx(output logic [9:0] bits, output int cyc);
        int guard;
        guard = 0;
        bits  = '0;
        cyc   = 0;
        while (!tx_en_o && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        while (tx_en_o && cyc < 2000) begin
            if ((cyc % BIT) == BIT / 2 && (cyc / BIT) < 10) bits[cyc / BIT] = tx_o;
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_ok(input logic [3:0] cmd, input logic [3:0] rid,
                          input int gap_bits, input bit poke);
        logic [9:0]  txbits;
        int          en_cyc;
        int          nd;
        logic [63:0] exp_data;
        nd       = nfields(rid);
        exp_data = '0;
        done_cnt = 0;
        rise_cnt = 0;
        do_start(cmd);
        chk("R10 fault flags cleared on start", 64'(fault_o), 64'd0);
        chk("R4 data cleared on start", data_o, 64'd0);
        capture_tx(txbits, en_cyc);
        chk("R1 request field bits", 64'(txbits), 64'({1'b1, cf_of(cmd), 1'b0}));
        chk("R2 transmit enable length", 64'(en_cyc), 64'(10 * BIT));
        idle(BIT);
        send_field(cf_of(rid), 1'b1);
        send_field(sv(rid), 1'b1);
        for (int k = 0; k < nd; k++) begin
            send_field(dv(rid, k), 1'b1);
            exp_data[8 * k +: 8] = dv(rid, k);
            if (poke && k == 0) begin
                start_i = 1'b1;
                cmd_i   = ~cmd;
                @(negedge clk);
                start_i = 1'b0;
            end
            if (gap_bits > 0) idle(gap_bits * BIT);
        end
        send_field(cv(rid), 1'b1);
        idle(3 * BIT);
        chk("R9 done pulse width and count", 64'(done_cnt), 64'd1);
        chk("R8 no fault on clean reply", 64'(fault_o), 64'd0);
        chk("R4 received id", 64'(id_o), 64'(rid));
        chk("R4 status field", 64'(status_o), 64'(sv(rid)));
        chk("R3 data fields by received id", data_o, exp_data);
        chk("R4 crc field", 64'(crc_o), 64'(cv(rid)));
        if (poke) chk("R11 start during transaction ignored", 64'(rise_cnt), 64'd1);
    endtask

    // kind: 0 parity, 1 sync pattern, 2 silent line, 3 cut short,
    //       4 data delimiter low, 5 control delimiter low
    task automatic run_fault(input int kind, input logic [2:0] exp_fault, input string what);
        logic [9:0] txbits;
        int         en_cyc;
        done_cnt = 0;
        do_start(4'h5);
        capture_tx(txbits, en_cyc);
        idle(BIT);
        case (kind)
            0: send_field({1'b1, 4'h5, 3'b010}, 1'b1);
            1: send_field({1'b0, 4'h0, 3'b110}, 1'b1);
            2: ;
            3: begin
                send_field(cf_of(4'h0), 1'b1);
                send_field(sv(4'h0), 1'b1);
                send_field(dv(4'h0, 0), 1'b1);
            end
            4: begin
                send_field(cf_of(4'h1), 1'b1);
                send_field(sv(4'h1), 1'b1);
                send_field(dv(4'h1, 0), 1'b0);
                rx_i = 1'b0;
                repeat (2 * BIT) @(negedge clk);
            end
            default: begin
                send_field(8'h00, 1'b0);
                rx_i = 1'b0;
                repeat (2 * BIT) @(negedge clk);
            end
        endcase
        idle(TO + 4 * BIT);
        chk(what, 64'(fault_o), 64'(exp_fault));
        chk("R8 no done after fault", 64'(done_cnt), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 reset tx idle high", 64'(tx_o), 64'd1);
        chk("R12 reset tx enable low", 64'(tx_en_o), 64'd0);
        chk("R12 reset done low", 64'(done_o), 64'd0);
        chk("R12 reset faults clear", 64'(fault_o), 64'd0);
        chk("R12 reset fields zero", {data_o[55:0], status_o}, 64'd0);

        for (int c = 0; c < 16; c++) run_ok(4'(c), 4'(c), 0, 1'b0);

        run_ok(4'h3, 4'h2, 0, 1'b0);
        run_ok(4'h0, 4'h3, 2, 1'b0);
        run_ok(4'h3, 4'h0, 0, 1'b0);
        run_ok(4'h1, 4'h1, 0, 1'b1);

        run_fault(0, 3'b001, "R6 parity fault");
        run_ok(4'h2, 4'h2, 0, 1'b0);
        run_fault(1, 3'b010, "R5 sync pattern fault");
        run_ok(4'h0, 4'h0, 0, 1'b0);
        run_fault(2, 3'b010, "R5 no reply before timeout");
        run_ok(4'h3, 4'h3, 0, 1'b0);
        run_fault(3, 3'b100, "R7 missing field timeout");
        run_ok(4'h1, 4'h1, 1, 1'b0);
        run_fault(4, 3'b100, "R7 data delimiter low");
        run_fault(5, 3'b100, "R7 control delimiter low precedence");
        run_ok(4'h6, 4'h6, 0, 1'b0);

        summary();
        $finish;
    end

endmodule